// File: doc/BRIEF.md
# Grouped four-bit pattern recognizer

This block watches a serial bit stream and cuts it into back-to-back, non-overlapping frames of four accepted bits. The first accepted bit after reset opens the first frame. On the last bit of a frame, the match output rises in that same cycle if the frame read 1,0,1,0 or 0,1,1,0, taken in arrival order. The machine then starts a new frame at once. A pattern that spans the boundary between two frames is never reported.

Inside, the recognizer is a Mealy machine reduced to seven states:
- a start state;
- two states that remember the first bit;
- one state for "first pair equal" and one for "first pair different";
- a third-bit state where no match is still possible;
- a third-bit candidate state.

A parameter picks how these states are stored. One choice is a dense three-bit binary code. The other is a six-flop code where the start state is all zeros and each other state owns one bit.

The input side is a valid/ready stream of single bits. The block never applies back-pressure. Ready is low only during reset and in the cycle that reset is asserted on the clock, and it is high from the first edge after reset is released. A bit counts only in a cycle where valid and ready are both high. The output has no handshake: it is a single-cycle pulse that qualifies the accepted bit.

Top module: `gfr_recognizer`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the next cycle shows bit_ready = 0 and match_o = 0. The next accepted bit after reset is the first bit of a new frame.
- R2: From the first clock edge with reset low onward, bit_ready stays 1. The block has no back-pressure.
- R3: A cycle with bit_valid = 0 is ignored. It neither advances the frame position nor changes the stored state, and match_o is 0 in that cycle.
- R4: match_o is 1 in the cycle of the fourth accepted bit of a frame when the frame's bits, in arrival order, are 1,0,1,0.
- R5: match_o is 1 in the cycle of the fourth accepted bit of a frame when the frame's bits, in arrival order, are 0,1,1,0.
- R6: For the other fourteen four-bit frames, match_o stays 0 on the fourth bit. This includes the near misses 1,0,1,1 and 0,1,1,1.
- R7: match_o is 0 on the first, second and third accepted bit of every frame.
- R8: Frames do not overlap. A matching pattern that starts part way into a frame and ends in the next one is not reported.
- R9: Reset in the middle of a frame discards the partial frame and realigns frame boundaries to the next accepted bit.
- R10: ENC_STYLE = 0 stores the state as a 3-bit binary code with start = 000. ENC_STYLE = 1 stores it as a 6-bit code with start = all zeros and at most one bit set. Both give identical match_o behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Serial bit present on bit_data |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| bit_data | input | 1 | Serial input bit |
| match_o | output | 1 | Pulses with the fourth bit of a matching frame |

## Verification
match_o is combinational from the accepted bit and the stored state. It is therefore due in the same cycle as the fourth accepted bit of a frame. The bench drives each bit just after a falling edge and samples the output 1 ns later, before the rising edge that stores the bit. bit_ready is due one rising edge after reset is released, so the reset sequence checks it low at the falling edge that follows a reset edge and checks it high from the next step onward. The reference model advances its frame position only on the rising edge of an accepted bit, which is the same edge at which the design changes state.

// File: rtl/gfr_pkg.sv
package gfr_pkg;
  // Abstract states of the reduced recognizer.
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,  // waiting for first bit of a frame
    ST_LEAD0   = 3'd1,  // first bit was 0
    ST_LEAD1   = 3'd2,  // first bit was 1
    ST_PAIR_EQ = 3'd3,  // first two bits equal
    ST_PAIR_NE = 3'd4,  // first two bits differ
    ST_MISS    = 3'd5,  // three bits seen, no match possible
    ST_CAND    = 3'd6   // three bits seen, a trailing 0 matches
  } gfr_st_e;

  localparam int NUM_ST = 7;

  // Width of the state register for a given encoding style.
  function automatic int code_width(input int style);
    return (style == 1) ? (NUM_ST - 1) : $clog2(NUM_ST);
  endfunction
endpackage

// File: rtl/gfr_next.sv
module gfr_next
  import gfr_pkg::*;
(
  input  gfr_st_e cur_st,
  input  logic    take,
  input  logic    din,
  output gfr_st_e nxt_st,
  output logic    hit
);
  always_comb begin
    nxt_st = cur_st;
    hit    = 1'b0;
    if (take) begin
      unique case (cur_st)
        ST_IDLE:    nxt_st = din ? ST_LEAD1 : ST_LEAD0;
        ST_LEAD0:   nxt_st = din ? ST_PAIR_NE : ST_PAIR_EQ;
        ST_LEAD1:   nxt_st = din ? ST_PAIR_EQ : ST_PAIR_NE;
        ST_PAIR_EQ: nxt_st = ST_MISS;
        ST_PAIR_NE: nxt_st = din ? ST_CAND : ST_MISS;
        ST_MISS:    nxt_st = ST_IDLE;
        ST_CAND: begin
          nxt_st = ST_IDLE;
          hit    = ~din;
        end
        default:    nxt_st = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfr_state_reg.sv
module gfr_state_reg
  import gfr_pkg::*;
#(
  parameter int STYLE = 0,
  parameter int SW    = code_width(STYLE)
) (
  input  logic          clk,
  input  logic          rst,
  input  gfr_st_e       d_st,
  output gfr_st_e       q_st,
  output logic [SW-1:0] code_q
);
  logic [SW-1:0] code_d;

  generate
    if (STYLE == 1) begin : g_zero_hot
      // Start is all zeros; state k (k >= 1) sets bit k-1.
      always_comb begin
        for (int i = 0; i < SW; i++) begin
          code_d[i] = (d_st == gfr_st_e'(3'(i + 1)));
        end
      end
      always_comb begin
        q_st = ST_IDLE;
        for (int i = 0; i < SW; i++) begin
          if (code_q[i]) q_st = gfr_st_e'(3'(i + 1));
        end
      end
    end else begin : g_binary
      assign code_d = SW'(d_st);
      assign q_st   = gfr_st_e'(3'(code_q));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end
endmodule

// File: rtl/gfr_recognizer.sv
module gfr_recognizer
  import gfr_pkg::*;
#(
  parameter int ENC_STYLE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_data,
  output logic match_o
);
  localparam int SW = code_width(ENC_STYLE);

  gfr_st_e       cur_st;
  gfr_st_e       nxt_st;
  logic [SW-1:0] st_code;
  logic          ready_q;
  logic          take;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign bit_ready = ready_q;
  assign take      = bit_valid & ready_q;

  gfr_next u_next (
    .cur_st (cur_st),
    .take   (take),
    .din    (bit_data),
    .nxt_st (nxt_st),
    .hit    (match_o)
  );

  gfr_state_reg #(.STYLE(ENC_STYLE), .SW(SW)) u_state (
    .clk    (clk),
    .rst    (rst),
    .d_st   (nxt_st),
    .q_st   (cur_st),
    .code_q (st_code)
  );
endmodule

// File: rtl/gfr_chk.sv
module gfr_chk #(
  parameter int STYLE = 0,
  parameter int SW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_valid,
  input logic          bit_ready,
  input logic          bit_data,
  input logic          match_o,
  input logic [SW-1:0] code
);
  logic [1:0] pos;
  logic [2:0] hist;
  logic       acc;
  logic       pat;

  assign acc = bit_valid && bit_ready;
  assign pat = ({hist, bit_data} == 4'b1010) || ({hist, bit_data} == 4'b0110);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= 2'd0;
      hist <= 3'd0;
    end else if (acc) begin
      pos  <= pos + 2'd1;
      hist <= {hist[1:0], bit_data};
    end
  end

  // R1
  reset_ready_low_chk: assert property (@(posedge clk) rst |=> !bit_ready && !match_o);
  // R2
  ready_high_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> bit_ready);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !acc |=> $stable(code));
  // R7
  z_last_slot_chk: assert property (@(posedge clk) disable iff (rst) match_o |-> acc && pos == 2'd3);
  // R4
  detect_chk: assert property (@(posedge clk) disable iff (rst) (acc && pos == 2'd3 && pat) |-> match_o);
  // R6
  miss_chk: assert property (@(posedge clk) disable iff (rst) (acc && pos == 2'd3 && !pat) |-> !match_o);

  generate
    if (STYLE == 1) begin : g_oh
      // R10
      code_onehot0_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(code));
    end
  endgenerate
endmodule

bind gfr_recognizer gfr_chk #(.STYLE(ENC_STYLE), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .bit_data  (bit_data),
  .match_o   (match_o),
  .code      (st_code)
);

// File: tb/gfr_recognizer_tb_top.sv
module gfr_recognizer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic rdy_b, rdy_h, z_b, z_h;

  int vectors = 0;
  int miscompares = 0;
  int m_pos = 0;
  logic [2:0] m_hist = 3'd0;

  always #2.5 clk = ~clk;

  gfr_recognizer #(.ENC_STYLE(0)) dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_ready(rdy_b),
    .bit_data(bit_data), .match_o(z_b));

  gfr_recognizer #(.ENC_STYLE(1)) dut_oh_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_ready(rdy_h),
    .bit_data(bit_data), .match_o(z_h));

  function automatic logic exp_match(input int pos, input logic [2:0] h, input logic b);
    return (pos == 3) && (({h, b} == 4'b1010) || ({h, b} == 4'b0110));
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    @(negedge clk);
    check("R1 ready", rdy_b, 1'b0);
    check("R1 ready R10", rdy_h, 1'b0);
    check("R1 match", z_b, 1'b0);
    rst = 1'b0;
    m_pos = 0;
    m_hist = 3'd0;
  endtask

  task automatic step(input logic v, input logic b, input string tag);
    logic e;
    string req;
    @(negedge clk);
    bit_valid = v;
    bit_data = b;
    #1;
    e = v && exp_match(m_pos, m_hist, b);
    if (tag != "") req = tag;
    else if (!v) req = "R3";
    else if (m_pos != 3) req = "R7";
    else if ({m_hist, b} == 4'b1010) req = "R4";
    else if ({m_hist, b} == 4'b0110) req = "R5";
    else req = "R6";
    check("R2 ready", rdy_b, 1'b1);
    check(req, z_b, e);
    check({req, " R10"}, z_h, e);
    @(posedge clk);
    if (v) begin
      m_hist = {m_hist[1:0], b};
      m_pos = (m_pos + 1) % 4;
    end
  endtask

  task automatic frame(input logic [3:0] g, input string tag);
    for (int i = 3; i >= 0; i--) step(1'b1, g[i], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset();
    // R4 R5 R6 R7: every frame value
    for (int g = 0; g < 16; g++) frame(4'(g), "");
    // R3: bubbles inside a matching frame
    step(1'b1, 1'b1, "");
    step(1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, "");
    step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, "");
    step(1'b1, 1'b0, "R4");
    // R8: 1010 straddling frames 1110 | 1000
    frame(4'b1110, "R8");
    frame(4'b1000, "R8");
    frame(4'b0111, "R6");
    frame(4'b0110, "R5");
    // R9: reset mid-frame then matching frame
    step(1'b1, 1'b0, "R9");
    step(1'b1, 1'b1, "R9");
    do_reset();
    frame(4'b1010, "R9");
    frame(4'b0110, "R9");
    // Random mix with fixed seed
    void'($urandom(32'h5eed_0042));
    for (int n = 0; n < 3000; n++) begin
      if (m_pos == 0 && ($urandom % 4) == 0)
        frame(($urandom % 2) ? 4'b1010 : 4'b0110, "");
      else
        step(($urandom % 4) != 0, 1'($urandom % 2), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule